// File: doc/BRIEF.md
# Dependence Latency Issue Scoreboard

This block decides, cycle by cycle, whether the instruction at the head of an in-order issue stage may issue or must wait for earlier instructions still in flight. Each request names an operation class, one destination register and two source registers. The block keeps, for every architectural register, the class of its most recent writer and the number of cycles since that writer issued. From these it derives a single go or stall decision for the current request. It works on timing alone. It holds no operand data, does no forwarding and does not model functional units.

The three dependence kinds are costed differently. A read of a pending register waits for the producer's latency. That latency is the producer class's default value, unless an entry in a fixed bypass table for the (producer class, consumer class) pair replaces it. Bypass entries can be guarded by a per-entry input bit. Among matching entries, the lowest-numbered guarded entry whose guard is high wins, and a matching unguarded entry is used only when no guarded one applies. A write to a pending register waits only as long as needed for the new result not to land before the old one. Writing a register that an earlier instruction reads costs nothing.

A stalled request is simply held at the inputs by the issue stage. It is judged again every cycle and changes no state until it issues.

Top module: `dep_scoreboard`

## Requirements
- R1: After reset is released, every register counts as ready, so the first valid request issues in the same cycle it is presented.
- R2: A read of a register with a pending write is accepted no earlier than L clock edges after the writer's accepting edge, where L is the writer class's default latency when no bypass entry applies. Class codes are 0 = integer (L = 2), 1 = multiply (L = 4), 2 = divide (L = 8) and 3 = float (L = 3). Both source ports are checked.
- R3: A write to a register with a pending write is accepted after max(1, Lp - Lc) edges, where Lp and Lc are the default latencies of the earlier and later writer.
- R4: Writing a register that an already accepted instruction reads adds no delay: the writer is accepted on the next edge.
- R5: Unguarded bypass entries replace the default read latency for their pair: float to integer, float to multiply and float to divide take 4 edges, and divide to integer takes 6 edges.
- R6: Guarded bypass entries are selected by bits of `byp_guard`. Bit 3 gives multiply to integer a latency of 2, bit 4 gives multiply to integer a latency of 3, bit 5 gives integer to integer a latency of 1, and bit 7 gives divide to integer a latency of 5. The lowest-numbered matching entry whose bit is high wins over higher-numbered ones and over unguarded entries. Guard bits of entries for other pairs have no effect.
- R7: `stall` is high exactly when a valid request is not accepted. A stalled request records nothing, so a request that is withdrawn while stalled leaves its destination ready.
- R8: Each accepted write restarts the timing of its destination register, so later readers are timed from the newest writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_class | input | 2 | Operation class of the request (0 int, 1 mul, 2 div, 3 float) |
| req_dst | input | 4 | Destination register index |
| req_src0 | input | 4 | First source register index |
| req_src1 | input | 4 | Second source register index |
| byp_guard | input | 8 | Per-entry guard bits of the bypass table |
| issue_go | output | 1 | Request is accepted at the coming clock edge |
| stall | output | 1 | Request is valid but must wait |

## Verification
Two things can fall in the same cycle. One is the acceptance of a new write to a register whose age is still counting: the restart must win over the increment. The bench provokes this by accepting two integer writes to one register on back-to-back edges and then timing a reader from the second write, not the first. The other is a request that hits a read hazard and a write hazard at once, or that carries guard bits for pairs other than its own. These cases are judged by measuring the exact number of edges between producer and consumer and comparing it with the value worked out from the latency rules.

// File: rtl/sbd_pkg.sv
`timescale 1ns/1ps
package sbd_pkg;

    localparam int CLS_W   = 2;
    localparam int LAT_W   = 4;
    localparam int NUM_BYP = 8;

    typedef enum logic [CLS_W-1:0] {
        CL_INT = 2'd0,
        CL_MUL = 2'd1,
        CL_DIV = 2'd2,
        CL_FLT = 2'd3
    } op_class_e;

    typedef struct packed {
        op_class_e        prod;
        op_class_e        cons;
        logic             guarded;
        logic [LAT_W-1:0] lat;
    } bypass_t;

    // Default result latency of each class.
    function automatic logic [LAT_W-1:0] base_latency(op_class_e c);
        case (c)
            CL_INT:  return LAT_W'(2);
            CL_MUL:  return LAT_W'(4);
            CL_DIV:  return LAT_W'(8);
            default: return LAT_W'(3);
        endcase
    endfunction

    // Bypass table; entry index is the priority order and the guard bit.
    function automatic bypass_t bypass_entry(int unsigned idx);
        bypass_t e;
        case (idx)
            0:       e = '{prod: CL_FLT, cons: CL_INT, guarded: 1'b0, lat: LAT_W'(4)};
            1:       e = '{prod: CL_FLT, cons: CL_MUL, guarded: 1'b0, lat: LAT_W'(4)};
            2:       e = '{prod: CL_FLT, cons: CL_DIV, guarded: 1'b0, lat: LAT_W'(4)};
            3:       e = '{prod: CL_MUL, cons: CL_INT, guarded: 1'b1, lat: LAT_W'(2)};
            4:       e = '{prod: CL_MUL, cons: CL_INT, guarded: 1'b1, lat: LAT_W'(3)};
            5:       e = '{prod: CL_INT, cons: CL_INT, guarded: 1'b1, lat: LAT_W'(1)};
            6:       e = '{prod: CL_DIV, cons: CL_INT, guarded: 1'b0, lat: LAT_W'(6)};
            default: e = '{prod: CL_DIV, cons: CL_INT, guarded: 1'b1, lat: LAT_W'(5)};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/sbd_lat_resolve.sv
`timescale 1ns/1ps
module sbd_lat_resolve
    import sbd_pkg::*;
(
    input  op_class_e            prod_cls,
    input  op_class_e            cons_cls,
    input  logic [NUM_BYP-1:0]   guard,
    output logic [LAT_W-1:0]     eff_lat
);

    logic             g_hit, u_hit;
    logic [LAT_W-1:0] g_lat, u_lat;

    always_comb begin
        bypass_t e;
        g_hit = 1'b0;
        u_hit = 1'b0;
        g_lat = '0;
        u_lat = '0;
        for (int i = 0; i < NUM_BYP; i++) begin
            e = bypass_entry(i);
            if (e.prod == prod_cls && e.cons == cons_cls) begin
                if (e.guarded) begin
                    if (guard[i] && !g_hit) begin
                        g_hit = 1'b1;
                        g_lat = e.lat;
                    end
                end else if (!u_hit) begin
                    u_hit = 1'b1;
                    u_lat = e.lat;
                end
            end
        end
    end

    // Guarded winner, then unguarded entry, then the class default.
    assign eff_lat = g_hit ? g_lat : (u_hit ? u_lat : base_latency(prod_cls));

endmodule

// File: rtl/sbd_age_file.sv
`timescale 1ns/1ps
module sbd_age_file
    import sbd_pkg::*;
#(
    parameter  int NREG    = 16,
    localparam int AW      = $clog2(NREG),
    localparam int AGE_MAX = (1 << LAT_W) - 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_idx,
    input  op_class_e                   wr_cls,
    output logic [NREG-1:0][LAT_W-1:0]  age_o,
    output logic [NREG-1:0][CLS_W-1:0]  cls_o
);

    // Age counts edges since the last accepted writer and saturates at
    // AGE_MAX, which exceeds every latency, so saturated means ready.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                age_o[r] <= LAT_W'(AGE_MAX);
                cls_o[r] <= CL_INT;
            end else if (wr_en && wr_idx == AW'(r)) begin
                age_o[r] <= LAT_W'(1);
                cls_o[r] <= wr_cls;
            end else if (age_o[r] != LAT_W'(AGE_MAX)) begin
                age_o[r] <= age_o[r] + LAT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dep_scoreboard.sv
`timescale 1ns/1ps
module dep_scoreboard
    import sbd_pkg::*;
#(
    parameter  int NREG = 16,
    localparam int AW   = $clog2(NREG),
    localparam int NSRC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [CLS_W-1:0]   req_class,
    input  logic [AW-1:0]      req_dst,
    input  logic [AW-1:0]      req_src0,
    input  logic [AW-1:0]      req_src1,
    input  logic [NUM_BYP-1:0] byp_guard,
    output logic               issue_go,
    output logic               stall
);

    op_class_e                  cons_cls;
    logic [NREG-1:0][LAT_W-1:0] age_q;
    logic [NREG-1:0][CLS_W-1:0] cls_q;
    logic [NSRC-1:0][AW-1:0]    src_idx;
    logic [NSRC-1:0]            src_ok;
    logic                       waw_ok;
    logic [LAT_W:0]             waw_sum;
    logic [LAT_W:0]             waw_need;

    assign cons_cls = op_class_e'(req_class);
    assign src_idx  = {req_src1, req_src0};

    // Read-after-write: each source waits for its pair latency.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        op_class_e        p_cls;
        logic [LAT_W-1:0] need;

        assign p_cls = op_class_e'(cls_q[src_idx[s]]);

        sbd_lat_resolve u_res (
            .prod_cls (p_cls),
            .cons_cls (cons_cls),
            .guard    (byp_guard),
            .eff_lat  (need)
        );

        assign src_ok[s] = age_q[src_idx[s]] >= need;
    end

    // Write-after-write: new result must not land before the old one,
    // i.e. age + Lc >= Lp. Write-after-read needs no check in order.
    assign waw_sum  = {1'b0, age_q[req_dst]} + {1'b0, base_latency(cons_cls)};
    assign waw_need = {1'b0, base_latency(op_class_e'(cls_q[req_dst]))};
    assign waw_ok   = waw_sum >= waw_need;

    assign issue_go = req_valid && !rst && (&src_ok) && waw_ok;
    assign stall    = req_valid && !rst && !issue_go;

    sbd_age_file #(
        .NREG (NREG)
    ) u_ages (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (issue_go),
        .wr_idx (req_dst),
        .wr_cls (cons_cls),
        .age_o  (age_q),
        .cls_o  (cls_q)
    );

endmodule

// File: rtl/sbd_checker.sv
`timescale 1ns/1ps
module sbd_checker
    import sbd_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic [CLS_W-1:0]           req_class,
    input logic [AW-1:0]              req_dst,
    input logic [AW-1:0]              req_src0,
    input logic                       issue_go,
    input logic                       stall,
    input logic [NREG-1:0][LAT_W-1:0] age_flat,
    input logic [NREG-1:0][CLS_W-1:0] cls_flat
);

    a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && req_valid) |-> issue_go);

    // Divide results are never visible one edge later, bypass or not.
    a_r2_div_blocks_next_reader: assert property (@(posedge clk) disable iff (rst)
        ($past(issue_go) && $past(req_class) == CL_DIV && req_valid
         && req_src0 == $past(req_dst)) |-> stall);

    a_r3_waw_div_then_int: assert property (@(posedge clk) disable iff (rst)
        ($past(issue_go) && $past(req_class) == CL_DIV && req_valid
         && req_class == CL_INT && req_dst == $past(req_dst)) |-> stall);

    a_r7_stall_no_update: assert property (@(posedge clk) disable iff (rst)
        $past(stall) |-> cls_flat == $past(cls_flat));

    a_r8_issue_restarts_age: assert property (@(posedge clk) disable iff (rst)
        $past(issue_go) |-> (age_flat[$past(req_dst)] == LAT_W'(1)
                             && cls_flat[$past(req_dst)] == $past(req_class)));

endmodule

bind dep_scoreboard sbd_checker #(.NREG(NREG), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_class (req_class),
    .req_dst   (req_dst),
    .req_src0  (req_src0),
    .issue_go  (issue_go),
    .stall     (stall),
    .age_flat  (age_q),
    .cls_flat  (cls_q)
);

// File: tb/dep_scoreboard_bench.sv
`timescale 1ns/1ps
module dep_scoreboard_bench;

    localparam int C_INT = 0, C_MUL = 1, C_DIV = 2, C_FLT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_class = '0;
    logic [3:0] req_dst = '0, req_src0 = '0, req_src1 = '0;
    logic [7:0] byp_guard = '0;
    logic       issue_go, stall;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dep_scoreboard u_dep_scoreboard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .req_dst(req_dst), .req_src0(req_src0), .req_src1(req_src1),
        .byp_guard(byp_guard), .issue_go(issue_go), .stall(stall)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int cls, input int dst,
                         input int s0, input int s1, input logic [7:0] g);
        req_valid = v;
        req_class = 2'(cls);
        req_dst   = 4'(dst);
        req_src0  = 4'(s0);
        req_src1  = 4'(s1);
        byp_guard = g;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            drive(0, 0, 15, 15, 15, 8'h00);
        end
    endtask

    // Counts edges until the currently driven request is accepted.
    task automatic measure(output int gap);
        bit got = 0;
        gap = 1;
        while (!got && gap < 20) begin
            #1;
            if (issue_go) got = 1;
            else begin
                @(negedge clk);
                gap++;
            end
        end
    endtask

    task automatic run_pair(input int pc, input int pd, input int ps,
                            input int cc, input int cd, input int cs0, input int cs1,
                            input logic [7:0] g, input int exp, input string req);
        int gap;
        idle(18);
        drive(1, pc, pd, ps, 15, 8'h00);
        #1;
        check(issue_go === 1'b1, {req, " producer accepted"}, int'(issue_go), 1);
        @(negedge clk);
        drive(1, cc, cd, cs0, cs1, g);
        measure(gap);
        check(gap == exp, {req, " consumer gap"}, gap, exp);
    endtask

    task automatic test_reset();
        @(negedge clk);
        drive(0, 0, 15, 15, 15, 8'h00);
        #1;
        check(issue_go == 0 && stall == 0, "R7 idle outputs", int'({issue_go, stall}), 0);
        @(negedge clk);
        drive(1, C_DIV, 1, 0, 2, 8'h00);
        #1;
        check(issue_go == 1, "R1 first request after reset", int'(issue_go), 1);
    endtask

    task automatic test_raw_default();
        run_pair(C_INT, 1, 15, C_INT, 14, 1, 15, 8'h00, 2, "R2 int->int");
        run_pair(C_MUL, 2, 15, C_MUL, 14, 15, 2, 8'h00, 4, "R2 mul->mul src1");
        run_pair(C_DIV, 3, 15, C_MUL, 14, 3, 15, 8'h00, 8, "R2 div->mul");
        run_pair(C_FLT, 4, 15, C_FLT, 14, 4, 15, 8'h00, 3, "R2 flt->flt");
    endtask

    task automatic test_bypass_plain();
        run_pair(C_FLT, 5, 15, C_INT, 14, 5, 15, 8'h00, 4, "R5 flt->int");
        run_pair(C_FLT, 5, 15, C_MUL, 14, 15, 5, 8'h00, 4, "R5 flt->mul");
        run_pair(C_FLT, 5, 15, C_DIV, 14, 5, 15, 8'h00, 4, "R5 flt->div");
        run_pair(C_DIV, 6, 15, C_INT, 14, 6, 15, 8'h00, 6, "R5 div->int");
    endtask

    task automatic test_bypass_guarded();
        run_pair(C_MUL, 2, 15, C_INT, 14, 2, 15, 8'b0001_1000, 2, "R6 both mul guards");
        run_pair(C_MUL, 2, 15, C_INT, 14, 2, 15, 8'b0001_0000, 3, "R6 second mul guard");
        run_pair(C_MUL, 2, 15, C_INT, 14, 2, 15, 8'b0010_0000, 4, "R6 foreign guard");
        run_pair(C_DIV, 6, 15, C_INT, 14, 6, 15, 8'b1000_0000, 5, "R6 guarded over plain");
        run_pair(C_INT, 1, 15, C_INT, 14, 1, 15, 8'b0010_0000, 1, "R6 int->int guard");
    endtask

    task automatic test_waw_anti();
        run_pair(C_DIV, 7, 15, C_INT, 7, 15, 15, 8'h00, 6, "R3 div then int");
        run_pair(C_INT, 8, 15, C_DIV, 8, 15, 15, 8'h00, 1, "R3 negative clamps");
        run_pair(C_MUL, 9, 15, C_INT, 9, 15, 15, 8'h00, 2, "R3 mul then int");
        run_pair(C_FLT, 10, 15, C_MUL, 10, 15, 15, 8'h00, 1, "R3 flt then mul");
        run_pair(C_INT, 11, 12, C_DIV, 12, 15, 15, 8'h00, 1, "R4 write after read");
    endtask

    task automatic test_stall_hold();
        idle(18);
        drive(1, C_DIV, 3, 15, 15, 8'h00);
        #1;
        check(issue_go == 1, "R7 producer accepted", int'(issue_go), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            drive(1, C_INT, 9, 3, 15, 8'h00);
            #1;
            check(stall == 1 && issue_go == 0, "R7 held request stalls",
                  int'({stall, issue_go}), 2);
        end
        @(negedge clk);
        drive(0, 0, 15, 15, 15, 8'h00);
        #1;
        check(stall == 0, "R7 withdrawn request", int'(stall), 0);
        @(negedge clk);
        drive(1, C_INT, 14, 9, 15, 8'h00);
        #1;
        check(issue_go == 1, "R7 stalled dst untouched", int'(issue_go), 1);
    endtask

    task automatic test_restart();
        int gap;
        idle(18);
        drive(1, C_INT, 4, 15, 15, 8'h00);
        #1;
        check(issue_go == 1, "R8 first write", int'(issue_go), 1);
        @(negedge clk);
        drive(1, C_INT, 4, 15, 15, 8'h00);
        #1;
        check(issue_go == 1, "R8 second write next edge", int'(issue_go), 1);
        @(negedge clk);
        drive(1, C_INT, 14, 4, 15, 8'h00);
        measure(gap);
        check(gap == 2, "R8 reader timed from newest write", gap, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_raw_default();
        test_bypass_plain();
        test_bypass_guarded();
        test_waw_anti();
        test_stall_hold();
        test_restart();
        idle(2);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule